// File: doc/BRIEF.md
# Firewall Region Configuration Validator

This block guards a small table of address-filter regions. Each entry holds an inclusive start and end address, a kind flag that marks it as a foreground or background region, an enable bit, a permission word and an owner host ID. Owner zero means the entry is unowned. A requester asks either to reprogram an entry or to change who owns it. The block accepts or rejects the request and returns a reason code. It writes the table only when it accepts.

For a reprogram request, the block walks every table entry in order, one entry per clock cycle. It compares the proposed range with each enabled entry other than the target. From these comparisons it decides whether the result would break the layering rules or the ownership rules between overlapping regions. An ownership request goes through the same walk, so every response arrives a fixed number of cycles after its request. The permission word is stored as given and is never interpreted. A combinational read port shows the contents of any entry.

Top module: `fwreg_validator`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are 0. Every entry reads back with enable 0, owner 0, kind 0, start 0, end 0 and permission 0.
- R2: A request is captured on a rising edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle on. `rsp_valid` is a single-cycle pulse in the cycle after the (N+1)-th rising edge that follows the capture edge, and `busy` is 0 in that cycle. `req_valid` has no effect while `busy` is 1.
- R3: `rsp_reason` encodes 0 accepted, 1 not owner, 2 background/background overlap, 3 foreground/foreground overlap, 4 span, 5 owner conflict. When more than one applies, the lowest nonzero code is reported. `rsp_accept` is 1 exactly when the code is 0.
- R4: A reprogram request (`req_op`=0) to an entry whose owner is nonzero and differs from `req_host` is rejected with code 1.
- R5: Two ranges overlap when neither end is below the other's start, with both bounds inclusive. Overlap checks skip entries whose enable is 0 and skip the target entry itself. A reprogram request with `req_en`=0 is not subjected to overlap checks.
- R6: A background request (`req_fg`=0) that overlaps an enabled background entry is rejected with code 2.
- R7: A foreground request (`req_fg`=1) that overlaps an enabled foreground entry is rejected with code 3.
- R8: A foreground request that overlaps two or more enabled background entries is rejected with code 4.
- R9: When the request and an overlapping entry are of different kinds, the owner of the request is the target entry's current owner. The request is rejected with code 5 if the background side's owner is nonzero and the foreground side's owner differs from it. This rule still allows an unowned background region under a foreground region owned by any host.
- R10: An accepted reprogram request writes start, end, kind, enable and the permission word exactly as supplied, and leaves the owner unchanged. A rejected request leaves every entry unchanged.
- R11: An ownership request (`req_op`=1) is accepted when the target's owner is 0 or equals `req_host`. It then sets the owner to `req_new_owner` and changes no other field. Otherwise it is rejected with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 reprogram entry, 1 change owner |
| req_idx | input | IDX_W | Target entry index |
| req_host | input | HOST_W | Requesting host ID |
| req_start | input | ADDR_W | Proposed start address (inclusive) |
| req_end | input | ADDR_W | Proposed end address (inclusive) |
| req_fg | input | 1 | Proposed kind: 1 foreground, 0 background |
| req_en | input | 1 | Proposed enable |
| req_perm | input | PERM_W | Permission word, stored unchecked |
| req_new_owner | input | HOST_W | Owner to set on an ownership request |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_accept | output | 1 | Request accepted |
| rsp_reason | output | 3 | Reason code |
| rd_idx | input | IDX_W | Read port entry index |
| rd_start | output | ADDR_W | Entry start address |
| rd_end | output | ADDR_W | Entry end address |
| rd_fg | output | 1 | Entry kind |
| rd_en | output | 1 | Entry enable |
| rd_owner | output | HOST_W | Entry owner |
| rd_perm | output | PERM_W | Entry permission word |

## Verification
The bench first goes after the corners of the overlap test. These are ranges that touch at a single shared address, a target that overlaps its own old range, and disabled neighbours. A design with exclusive bounds, or one that counts its own entry or disabled entries, would then give the wrong overlap verdicts. It then builds a foreground region that covers two background regions and also breaks the owner rule, and a foreground overlap that also hits an owned background. A design with the wrong priority would report the wrong code. Ownership cases cover a non-owner trying to reprogram or transfer, an unowned background under an owned foreground, and an unowned foreground over an owned background. A design that swapped the two sides of the owner rule would accept or reject the wrong one of these. Stray requests held high during a busy walk show whether the block captures requests it should ignore.

// File: rtl/fwreg_pkg.sv
package fwreg_pkg;

    typedef enum logic [2:0] {
        RSN_OK             = 3'd0,
        RSN_NOT_OWNER      = 3'd1,
        RSN_BG_BG          = 3'd2,
        RSN_FG_FG          = 3'd3,
        RSN_SPAN           = 3'd4,
        RSN_OWNER_CONFLICT = 3'd5
    } reason_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    localparam logic OP_CONFIG = 1'b0;
    localparam logic OP_OWNER  = 1'b1;

endpackage

// File: rtl/fwreg_table.sv
module fwreg_table #(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int HOST_W = 8,
    parameter int PERM_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic              wr_own,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_lo,
    input  logic [ADDR_W-1:0] wr_hi,
    input  logic              wr_fg,
    input  logic              wr_en,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [HOST_W-1:0] wr_owner,
    input  logic [IDX_W-1:0]  ext_idx,
    output logic [ADDR_W-1:0] ext_lo,
    output logic [ADDR_W-1:0] ext_hi,
    output logic              ext_fg,
    output logic              ext_en,
    output logic [HOST_W-1:0] ext_owner,
    output logic [PERM_W-1:0] ext_perm,
    input  logic [IDX_W-1:0]  scn_idx,
    output logic [ADDR_W-1:0] scn_lo,
    output logic [ADDR_W-1:0] scn_hi,
    output logic              scn_fg,
    output logic              scn_en,
    output logic [HOST_W-1:0] scn_owner,
    input  logic [IDX_W-1:0]  tgt_idx,
    output logic [HOST_W-1:0] tgt_owner
);

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic              fg;
        logic              en;
        logic [HOST_W-1:0] owner;
        logic [PERM_W-1:0] perm;
    } entry_t;

    entry_t ent_vec [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        entry_t ent_d, ent_q;
        logic   sel;

        assign sel = (wr_idx == IDX_W'(g));

        always_comb begin
            ent_d = ent_q;
            if (wr_cfg && sel) begin
                ent_d.lo   = wr_lo;
                ent_d.hi   = wr_hi;
                ent_d.fg   = wr_fg;
                ent_d.en   = wr_en;
                ent_d.perm = wr_perm;
            end
            if (wr_own && sel) begin
                ent_d.owner = wr_owner;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_vec[g] = ent_q;
    end

    entry_t ext_e, scn_e, tgt_e;

    always_comb begin
        ext_e = '0;
        scn_e = '0;
        tgt_e = '0;
        if (int'(ext_idx) < N) ext_e = ent_vec[ext_idx];
        if (int'(scn_idx) < N) scn_e = ent_vec[scn_idx];
        if (int'(tgt_idx) < N) tgt_e = ent_vec[tgt_idx];
    end

    assign ext_lo    = ext_e.lo;
    assign ext_hi    = ext_e.hi;
    assign ext_fg    = ext_e.fg;
    assign ext_en    = ext_e.en;
    assign ext_owner = ext_e.owner;
    assign ext_perm  = ext_e.perm;
    assign scn_lo    = scn_e.lo;
    assign scn_hi    = scn_e.hi;
    assign scn_fg    = scn_e.fg;
    assign scn_en    = scn_e.en;
    assign scn_owner = scn_e.owner;
    assign tgt_owner = tgt_e.owner;

endmodule

// File: rtl/fwreg_pair_check.sv
module fwreg_pair_check #(
    parameter int ADDR_W = 32,
    parameter int HOST_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [IDX_W-1:0]  tgt_idx,
    input  logic [IDX_W-1:0]  scn_idx,
    input  logic [ADDR_W-1:0] req_lo,
    input  logic [ADDR_W-1:0] req_hi,
    input  logic              req_fg,
    input  logic [HOST_W-1:0] tgt_owner,
    input  logic [ADDR_W-1:0] ent_lo,
    input  logic [ADDR_W-1:0] ent_hi,
    input  logic              ent_fg,
    input  logic              ent_en,
    input  logic [HOST_W-1:0] ent_owner,
    output logic              hit_bgbg,
    output logic              hit_fgfg,
    output logic              hit_bg,
    output logic              hit_conf
);

    logic              live;
    logic              ovl;
    logic [HOST_W-1:0] fg_own;
    logic [HOST_W-1:0] bg_own;

    assign live   = ent_en && (scn_idx != tgt_idx);
    assign ovl    = live && !(ent_hi < req_lo) && !(req_hi < ent_lo);
    assign fg_own = req_fg ? tgt_owner : ent_owner;
    assign bg_own = req_fg ? ent_owner : tgt_owner;

    assign hit_bgbg = ovl && !req_fg && !ent_fg;
    assign hit_fgfg = ovl &&  req_fg &&  ent_fg;
    assign hit_bg   = ovl &&  req_fg && !ent_fg;
    assign hit_conf = ovl && (req_fg != ent_fg) && (bg_own != '0) && (fg_own != bg_own);

endmodule

// File: rtl/fwreg_ctrl.sv
module fwreg_ctrl
    import fwreg_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int HOST_W = 8,
    parameter int PERM_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [HOST_W-1:0] req_host,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic              req_fg,
    input  logic              req_en,
    input  logic [PERM_W-1:0] req_perm,
    input  logic [HOST_W-1:0] req_new_owner,
    input  logic              hit_bgbg,
    input  logic              hit_fgfg,
    input  logic              hit_bg,
    input  logic              hit_conf,
    input  logic [HOST_W-1:0] tgt_owner,
    output logic [IDX_W-1:0]  scn_idx,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic [ADDR_W-1:0] cur_lo,
    output logic [ADDR_W-1:0] cur_hi,
    output logic              cur_fg,
    output logic              cur_en,
    output logic [PERM_W-1:0] cur_perm,
    output logic [HOST_W-1:0] cur_new_owner,
    output logic              wr_cfg,
    output logic              wr_own,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_accept,
    output logic [2:0]        rsp_reason
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        state_e            st;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  scan;
        logic              op;
        logic [HOST_W-1:0] host;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic              fg;
        logic              en;
        logic [PERM_W-1:0] perm;
        logic [HOST_W-1:0] new_owner;
        logic              f_bgbg;
        logic              f_fgfg;
        logic              f_conf;
        logic [1:0]        bg_cnt;
        logic              rsp_v;
        logic              rsp_ok;
        reason_e           rsn;
    } ctl_t;

    ctl_t    ctl_d, ctl_q;
    reason_e rsn;
    logic    not_owner;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        wr_cfg      = 1'b0;
        wr_own      = 1'b0;
        rsn         = RSN_OK;
        not_owner   = (tgt_owner != '0) && (tgt_owner != ctl_q.host);

        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st        = ST_SCAN;
                    ctl_d.idx       = req_idx;
                    ctl_d.scan      = '0;
                    ctl_d.op        = req_op;
                    ctl_d.host      = req_host;
                    ctl_d.lo        = req_start;
                    ctl_d.hi        = req_end;
                    ctl_d.fg        = req_fg;
                    ctl_d.en        = req_en;
                    ctl_d.perm      = req_perm;
                    ctl_d.new_owner = req_new_owner;
                    ctl_d.f_bgbg    = 1'b0;
                    ctl_d.f_fgfg    = 1'b0;
                    ctl_d.f_conf    = 1'b0;
                    ctl_d.bg_cnt    = 2'd0;
                end
            end
            ST_SCAN: begin
                ctl_d.f_bgbg = ctl_q.f_bgbg | hit_bgbg;
                ctl_d.f_fgfg = ctl_q.f_fgfg | hit_fgfg;
                ctl_d.f_conf = ctl_q.f_conf | hit_conf;
                if (hit_bg && (ctl_q.bg_cnt != 2'd2)) begin
                    ctl_d.bg_cnt = ctl_q.bg_cnt + 2'd1;
                end
                if (ctl_q.scan == LAST) begin
                    ctl_d.st = ST_RESP;
                end else begin
                    ctl_d.scan = ctl_q.scan + IDX_W'(1);
                end
            end
            ST_RESP: begin
                if (not_owner) begin
                    rsn = RSN_NOT_OWNER;
                end else if ((ctl_q.op == OP_CONFIG) && ctl_q.en) begin
                    if (ctl_q.f_bgbg)              rsn = RSN_BG_BG;
                    else if (ctl_q.f_fgfg)         rsn = RSN_FG_FG;
                    else if (ctl_q.bg_cnt == 2'd2) rsn = RSN_SPAN;
                    else if (ctl_q.f_conf)         rsn = RSN_OWNER_CONFLICT;
                end
                wr_cfg       = (rsn == RSN_OK) && (ctl_q.op == OP_CONFIG);
                wr_own       = (rsn == RSN_OK) && (ctl_q.op == OP_OWNER);
                ctl_d.rsp_v  = 1'b1;
                ctl_d.rsp_ok = (rsn == RSN_OK);
                ctl_d.rsn    = rsn;
                ctl_d.st     = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= ST_IDLE;
            ctl_q.rsn <= RSN_OK;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign scn_idx       = ctl_q.scan;
    assign tgt_idx       = ctl_q.idx;
    assign cur_lo        = ctl_q.lo;
    assign cur_hi        = ctl_q.hi;
    assign cur_fg        = ctl_q.fg;
    assign cur_en        = ctl_q.en;
    assign cur_perm      = ctl_q.perm;
    assign cur_new_owner = ctl_q.new_owner;
    assign busy          = (ctl_q.st != ST_IDLE);
    assign rsp_valid     = ctl_q.rsp_v;
    assign rsp_accept    = ctl_q.rsp_ok;
    assign rsp_reason    = ctl_q.rsn;

endmodule

// File: rtl/fwreg_validator.sv
module fwreg_validator #(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int HOST_W = 8,
    parameter int PERM_W = 16,
    parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [HOST_W-1:0] req_host,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic              req_fg,
    input  logic              req_en,
    input  logic [PERM_W-1:0] req_perm,
    input  logic [HOST_W-1:0] req_new_owner,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_accept,
    output logic [2:0]        rsp_reason,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_start,
    output logic [ADDR_W-1:0] rd_end,
    output logic              rd_fg,
    output logic              rd_en,
    output logic [HOST_W-1:0] rd_owner,
    output logic [PERM_W-1:0] rd_perm
);

    logic [IDX_W-1:0]  scn_idx, tgt_idx;
    logic [ADDR_W-1:0] cur_lo, cur_hi, scn_lo, scn_hi;
    logic              cur_fg, cur_en, scn_fg, scn_en;
    logic [PERM_W-1:0] cur_perm;
    logic [HOST_W-1:0] cur_new_owner, scn_owner, tgt_owner;
    logic              wr_cfg, wr_own;
    logic              hit_bgbg, hit_fgfg, hit_bg, hit_conf;

    fwreg_ctrl #(
        .N(N), .ADDR_W(ADDR_W), .HOST_W(HOST_W), .PERM_W(PERM_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx), .req_host(req_host),
        .req_start(req_start), .req_end(req_end), .req_fg(req_fg), .req_en(req_en),
        .req_perm(req_perm), .req_new_owner(req_new_owner),
        .hit_bgbg(hit_bgbg), .hit_fgfg(hit_fgfg), .hit_bg(hit_bg), .hit_conf(hit_conf),
        .tgt_owner(tgt_owner),
        .scn_idx(scn_idx), .tgt_idx(tgt_idx),
        .cur_lo(cur_lo), .cur_hi(cur_hi), .cur_fg(cur_fg), .cur_en(cur_en),
        .cur_perm(cur_perm), .cur_new_owner(cur_new_owner),
        .wr_cfg(wr_cfg), .wr_own(wr_own),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_reason(rsp_reason)
    );

    fwreg_table #(
        .N(N), .ADDR_W(ADDR_W), .HOST_W(HOST_W), .PERM_W(PERM_W), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_cfg(wr_cfg), .wr_own(wr_own), .wr_idx(tgt_idx),
        .wr_lo(cur_lo), .wr_hi(cur_hi), .wr_fg(cur_fg), .wr_en(cur_en),
        .wr_perm(cur_perm), .wr_owner(cur_new_owner),
        .ext_idx(rd_idx), .ext_lo(rd_start), .ext_hi(rd_end), .ext_fg(rd_fg),
        .ext_en(rd_en), .ext_owner(rd_owner), .ext_perm(rd_perm),
        .scn_idx(scn_idx), .scn_lo(scn_lo), .scn_hi(scn_hi), .scn_fg(scn_fg),
        .scn_en(scn_en), .scn_owner(scn_owner),
        .tgt_idx(tgt_idx), .tgt_owner(tgt_owner)
    );

    fwreg_pair_check #(
        .ADDR_W(ADDR_W), .HOST_W(HOST_W), .IDX_W(IDX_W)
    ) u_pair (
        .tgt_idx(tgt_idx), .scn_idx(scn_idx),
        .req_lo(cur_lo), .req_hi(cur_hi), .req_fg(cur_fg), .tgt_owner(tgt_owner),
        .ent_lo(scn_lo), .ent_hi(scn_hi), .ent_fg(scn_fg), .ent_en(scn_en),
        .ent_owner(scn_owner),
        .hit_bgbg(hit_bgbg), .hit_fgfg(hit_fgfg), .hit_bg(hit_bg), .hit_conf(hit_conf)
    );

endmodule

// File: rtl/fwreg_checker.sv
module fwreg_checker #(
    parameter int N = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       rsp_valid,
    input logic       rsp_accept,
    input logic [2:0] rsp_reason,
    input logic       wr_cfg,
    input logic       wr_own
);

    localparam int            CW  = $clog2(N + 3) + 1;
    localparam logic [CW-1:0] LAT = CW'(N + 2);

    logic [CW-1:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (req_valid && !busy) begin
            lat_cnt <= CW'(1);
        end else if (lat_cnt == LAT) begin
            lat_cnt <= '0;
        end else if (lat_cnt != '0) begin
            lat_cnt <= lat_cnt + CW'(1);
        end
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == (lat_cnt == LAT)); // R2
    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_cnt != '0) && (lat_cnt != LAT)) |-> busy); // R2
    AST_IDLE_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy); // R2
    AST_ACCEPT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_accept == (rsp_reason == 3'd0))); // R3
    AST_REASON_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_reason <= 3'd5)); // R3
    AST_WRITE_MEANS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg || wr_own) |=> (rsp_valid && rsp_accept)); // R10
    AST_ACCEPT_MEANS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_accept) |-> $past(wr_cfg || wr_own)); // R10
    AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_cfg && wr_own)); // R11

endmodule

bind fwreg_validator fwreg_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_reason(rsp_reason),
    .wr_cfg(wr_cfg), .wr_own(wr_own)
);

// File: tb/fwreg_validator_test.sv
`timescale 1ns/1ps
module fwreg_validator_test;

    localparam int N      = 8;
    localparam int ADDR_W = 32;
    localparam int HOST_W = 8;
    localparam int PERM_W = 16;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_op = 1'b0;
    logic [IDX_W-1:0]  req_idx = '0;
    logic [HOST_W-1:0] req_host = '0;
    logic [ADDR_W-1:0] req_start = '0;
    logic [ADDR_W-1:0] req_end = '0;
    logic              req_fg = 1'b0;
    logic              req_en = 1'b0;
    logic [PERM_W-1:0] req_perm = '0;
    logic [HOST_W-1:0] req_new_owner = '0;
    logic              busy, rsp_valid, rsp_accept;
    logic [2:0]        rsp_reason;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [ADDR_W-1:0] rd_start, rd_end;
    logic              rd_fg, rd_en;
    logic [HOST_W-1:0] rd_owner;
    logic [PERM_W-1:0] rd_perm;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_lo [N];
    int m_hi [N];
    int m_fg [N];
    int m_en [N];
    int m_own [N];
    int m_perm [N];

    always #2.5 clk = ~clk;

    fwreg_validator #(.N(N), .ADDR_W(ADDR_W), .HOST_W(HOST_W), .PERM_W(PERM_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
        .req_host(req_host), .req_start(req_start), .req_end(req_end), .req_fg(req_fg),
        .req_en(req_en), .req_perm(req_perm), .req_new_owner(req_new_owner),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_reason(rsp_reason),
        .rd_idx(rd_idx), .rd_start(rd_start), .rd_end(rd_end), .rd_fg(rd_fg), .rd_en(rd_en),
        .rd_owner(rd_owner), .rd_perm(rd_perm)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_reason(int op, int idx, int host, int lo, int hi, int fg, int en);
        int own, nbg, fo, bo;
        bit bb, ff, cf;
        own = m_own[idx];
        nbg = 0; bb = 0; ff = 0; cf = 0;
        if (own != 0 && own != host) return 1;
        if (op == 1 || en == 0) return 0;
        for (int j = 0; j < N; j++) begin
            if (j != idx && m_en[j] != 0 && !(m_hi[j] < lo) && !(hi < m_lo[j])) begin
                if (fg == 0 && m_fg[j] == 0) bb = 1;
                if (fg == 1 && m_fg[j] == 1) ff = 1;
                if (fg == 1 && m_fg[j] == 0) nbg++;
                if (fg != m_fg[j]) begin
                    fo = (fg == 1) ? own : m_own[j];
                    bo = (fg == 1) ? m_own[j] : own;
                    if (bo != 0 && fo != bo) cf = 1;
                end
            end
        end
        if (bb) return 2;
        if (ff) return 3;
        if (nbg >= 2) return 4;
        if (cf) return 5;
        return 0;
    endfunction

    function automatic string tag_of(int op, int rsn);
        case (rsn)
            0: return (op == 1) ? "R11" : "R10";
            1: return (op == 1) ? "R11" : "R4";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_table(input string req);
        bit ok;
        int bad;
        ok = 1; bad = -1;
        for (int i = 0; i < N; i++) begin
            rd_idx = IDX_W'(i);
            #0.1;
            if (int'(rd_start) != m_lo[i] || int'(rd_end) != m_hi[i] || int'(rd_fg) != m_fg[i] ||
                int'(rd_en) != m_en[i] || int'(rd_owner) != m_own[i] || int'(rd_perm) != m_perm[i]) begin
                if (ok) bad = i;
                ok = 0;
            end
        end
        check(ok, req, bad, -1, "table readback mismatch at entry (actual=index)");
    endtask

    task automatic do_req(input int op, input int idx, input int host, input int lo, input int hi,
                          input int fg, input int en, input int perm, input int nown,
                          input bit noise, input int want);
        int    er;
        string tg;
        er = exp_reason(op, idx, host, lo, hi, fg, en);
        tg = tag_of(op, er);
        if (want >= 0) check(er == want, tg, er, want, "bench scenario setup");
        @(negedge clk);
        req_valid = 1'b1; req_op = op[0]; req_idx = IDX_W'(idx); req_host = HOST_W'(host);
        req_start = ADDR_W'(lo); req_end = ADDR_W'(hi); req_fg = fg[0]; req_en = en[0];
        req_perm = PERM_W'(perm); req_new_owner = HOST_W'(nown);
        @(posedge clk);
        @(negedge clk);
        req_valid = noise;
        if (noise) begin
            req_op = ~req_op; req_idx = req_idx + 1'b1; req_host = req_host + 1'b1;
            req_start = 0; req_end = 200; req_fg = ~req_fg; req_perm = ~req_perm;
        end
        check(busy == 1'b1, "R2", int'(busy), 1, "busy after capture");
        for (int k = 1; k < N; k++) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2", int'(rsp_valid), 0, "response too early");
        @(negedge clk);
        check(rsp_valid == 1'b1 && busy == 1'b0, "R2", int'(rsp_valid), 1, "response pulse at fixed latency");
        check(int'(rsp_reason) == er, tg, int'(rsp_reason), er, "reason code");
        check(rsp_accept == (er == 0), "R3", int'(rsp_accept), int'(er == 0), "accept flag");
        if (er == 0) begin
            if (op == 1) begin
                m_own[idx] = nown;
            end else begin
                m_lo[idx] = lo; m_hi[idx] = hi; m_fg[idx] = fg; m_en[idx] = en; m_perm[idx] = perm;
            end
        end
        check_table(tg);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2", int'(rsp_valid), 0, "response lasts one cycle");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lo, hi, seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        for (int i = 0; i < N; i++) begin
            m_lo[i] = 0; m_hi[i] = 0; m_fg[i] = 0; m_en[i] = 0; m_own[i] = 0; m_perm[i] = 0;
        end
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && rsp_valid == 1'b0, "R1", int'(busy), 0, "busy/rsp in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && rsp_valid == 1'b0, "R1", int'(rsp_valid), 0, "idle after reset");
        check_table("R1");

        // R11 claim, R10 program, R4 foreign reprogram, R11 foreign transfer
        do_req(1, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0);
        do_req(0, 0, 1, 10, 20, 0, 1, 16'hA5A5, 0, 0, 0);
        do_req(0, 0, 2, 40, 45, 0, 1, 16'h1111, 0, 0, 1);
        do_req(1, 0, 2, 0, 0, 0, 0, 0, 2, 0, 1);
        // R5 inclusive bound touching at 20 -> R6
        do_req(0, 1, 1, 20, 30, 0, 1, 1, 0, 0, 2);
        do_req(0, 1, 1, 21, 30, 0, 1, 2, 0, 0, 0);
        // R8 span takes priority over owner conflict
        do_req(0, 2, 1, 15, 25, 1, 1, 3, 0, 0, 4);
        do_req(1, 2, 5, 0, 0, 0, 0, 0, 1, 0, 0);
        do_req(0, 2, 1, 12, 18, 1, 1, 16'hFFFF, 0, 0, 0);
        // R7 fg-fg beats conflict
        do_req(0, 3, 2, 18, 19, 1, 1, 4, 0, 0, 3);
        // R9 unowned fg over owned bg; owned fg of other host over owned bg
        do_req(0, 3, 2, 11, 11, 1, 1, 5, 0, 0, 5);
        do_req(1, 3, 2, 0, 0, 0, 0, 0, 2, 0, 0);
        do_req(0, 3, 2, 11, 11, 1, 1, 5, 0, 0, 5);
        // R9 unowned bg under fg owned by any host is allowed
        do_req(0, 4, 7, 40, 50, 0, 1, 6, 0, 0, 0);
        do_req(1, 5, 3, 0, 0, 0, 0, 0, 3, 0, 0);
        do_req(0, 5, 3, 45, 48, 1, 1, 7, 0, 0, 0);
        // R5 disabled entries and self ignored; disable skips checks
        do_req(0, 0, 1, 10, 20, 0, 0, 8, 0, 0, 0);
        do_req(0, 6, 4, 10, 15, 0, 1, 9, 0, 0, 0);
        do_req(0, 1, 1, 21, 31, 0, 1, 10, 0, 0, 0);
        do_req(0, 7, 4, 0, 100, 0, 0, 11, 0, 0, 0);
        // R2 stray requests while busy are ignored
        do_req(0, 7, 4, 90, 95, 0, 1, 12, 0, 1, 0);

        // random phase
        for (int n = 0; n < 300; n++) begin
            lo = $urandom % 64;
            hi = lo + ($urandom % 12);
            do_req(($urandom % 4 == 0) ? 1 : 0, $urandom % N, $urandom % 4, lo, hi,
                   $urandom % 2, ($urandom % 7 == 0) ? 0 : 1, $urandom % 65536,
                   $urandom % 4, ($urandom % 4 == 0), -1);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule